// File: doc/BRIEF.md
# Sequence-Armed Watchdog Reset Timer

This block is a hardware watchdog for a small microcontroller core. It sits idle after every reset. Software arms it by writing a two-byte key, first 0x1E and then 0xE1, to a service register. Once armed, a prescale counter chained to a programmable counter advances on every machine-cycle enable. If software does not write the same key again before the selected interval runs out, the block raises its reset output for a fixed number of oscillator clocks.

A 3-bit interval select in a separate program register chooses which stage of the count chain ends the interval. With select value n and the default widths, the interval is 2^(14+n) machine cycles. With a 12 MHz oscillator and 12 clocks per machine cycle, this runs from about 16 ms to about 2 s. Once armed, software cannot disarm the watchdog. Only the external reset or the watchdog's own time-out returns it to the idle state.

Top module: `wdog_seq_top`

## Requirements
- R1: While `rst` is high, and from then on until a complete key has been written, `rst_out` stays low and the watchdog does not count.
- R2: Writing 0x1E and then 0xE1 to address SVC_ADDR arms the watchdog and starts the interval from zero. `rst_out` rises exactly 2^(PRESCALE_W+n) enabled machine cycles after the clock edge that took the 0xE1 write, where n is the active select value.
- R3: The count advances only on edges where `mc_en` is high. Edges with `mc_en` low add nothing to the interval.
- R4: Bits 2:0 of a write to address PRG_ADDR set the select value n (0 to 7). Each step of n doubles the interval.
- R5: Any write to SVC_ADDR that is not the expected next key byte drops a partial key. A write of 0x1E always begins a new key attempt, even directly after another 0x1E.
- R6: Writing the full key while armed clears the count, so the next time-out falls a full interval after the new 0xE1 write.
- R7: While armed, writes of other values or of an unfinished key to SVC_ADDR neither disarm the watchdog nor move its time-out.
- R8: A new select value takes effect only at the next key completion. An interval already running keeps the select value it started with.
- R9: Each time-out drives `rst_out` high for exactly PULSE_CLKS clock cycles (96 by default).
- R10: A time-out clears the armed state, the count, the key tracker and the select value. Writes made while `rst_out` is high have no effect, and no further pulse follows unless the watchdog is armed again.
- R11: Asserting `rst` during a pulse does not shorten it. Asserting `rst` while armed disarms the watchdog, so no pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | External synchronous active-high reset |
| mc_en | input | 1 | Machine-cycle enable, one clock wide per machine cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rst_out | output | 1 | Registered watchdog reset pulse |

## Verification
The bench builds the block with PRESCALE_W set to 3 instead of 14, and keeps the 7-bit programmable counter and the 96-clock pulse unchanged. All eight select values then time out within 8 to 1024 cycles. Each tap of the chain, including the carry out of the full programmable counter, can therefore be timed to the exact cycle, and the true pulse length can be checked after every time-out.

// File: rtl/wdog_seq_pkg.sv
package wdog_seq_pkg;

  // Key bytes, in the order they must arrive at the service register
  localparam logic [7:0] KEY_FIRST  = 8'h1E;
  localparam logic [7:0] KEY_SECOND = 8'hE1;

  // Progress through the two-byte key
  typedef enum logic {
    KEY_IDLE = 1'b0,
    KEY_HALF = 1'b1
  } key_state_t;

endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              key_done
);
  import wdog_seq_pkg::*;

  key_state_t state_q;
  logic       svc_hit;

  assign svc_hit  = wr_en && (wr_addr == SVC_ADDR);
  assign key_done = svc_hit && (state_q == KEY_HALF) && (wr_data == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (clr) begin
      state_q <= KEY_IDLE;
    end else if (svc_hit) begin
      // A first key byte always opens a new attempt; anything else closes it
      state_q <= (wr_data == KEY_FIRST) ? KEY_HALF : KEY_IDLE;
    end
  end

endmodule

// File: rtl/wdog_chain.sv
module wdog_chain #(
  parameter int PRESCALE_W = 14,
  parameter int PROG_W     = 7,
  parameter int SEL_W      = 3
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             restart,
  input  logic             step,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);
  localparam int NSEL = 2 ** SEL_W;

  logic [PRESCALE_W-1:0] pre_q;
  logic [PROG_W-1:0]     prog_q;
  logic                  pre_carry;
  logic [NSEL-1:0]       tap;

  assign pre_carry = &pre_q;

  always_ff @(posedge clk) begin
    if (clr || restart) begin
      pre_q  <= '0;
      prog_q <= '0;
    end else if (step) begin
      pre_q <= pre_q + 1'b1;
      if (pre_carry) begin
        prog_q <= prog_q + 1'b1;
      end
    end
  end

  // tap[i]: the next step carries into bit PRESCALE_W+i of the whole chain
  for (genvar i = 0; i < NSEL; i++) begin : g_tap
    if (i == 0) begin : g_first
      assign tap[i] = pre_carry;
    end else if (i <= PROG_W) begin : g_mid
      assign tap[i] = tap[i-1] & prog_q[i-1];
    end else begin : g_beyond
      assign tap[i] = tap[i-1];
    end
  end

  assign expire = step && tap[sel];

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_CLKS = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse_o
);
  localparam int CW = $clog2(PULSE_CLKS + 1);

  logic [CW-1:0] cnt_q;

  // A pulse in progress runs to its end regardless of rst
  always_ff @(posedge clk) begin
    if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        pulse_o <= 1'b0;
      end
    end else if (rst) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (fire) begin
      cnt_q   <= CW'(PULSE_CLKS);
      pulse_o <= 1'b1;
    end
  end

endmodule

// File: rtl/wdog_seq_top.sv
module wdog_seq_top #(
  parameter int                PRESCALE_W = 14,
  parameter int                PROG_W     = 7,
  parameter int                SEL_W      = 3,
  parameter int                PULSE_CLKS = 96,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR   = 8'h40,
  parameter logic [ADDR_W-1:0] PRG_ADDR   = 8'h41
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mc_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              rst_out
);

  logic             armed_q;
  logic [SEL_W-1:0] sel_reg_q;
  logic [SEL_W-1:0] sel_act_q;
  logic             key_done;
  logic             kick;
  logic             expire;
  logic             ovf;
  logic             clr;

  // Internal clear: external reset, a time-out, or a pulse in progress
  assign ovf  = expire && !rst;
  assign clr  = rst || ovf || rst_out;
  assign kick = key_done && !clr;

  always_ff @(posedge clk) begin
    if (clr) begin
      armed_q   <= 1'b0;
      sel_reg_q <= '0;
      sel_act_q <= '0;
    end else begin
      if (kick) begin
        armed_q   <= 1'b1;
        sel_act_q <= sel_reg_q;
      end
      if (wr_en && (wr_addr == PRG_ADDR)) begin
        sel_reg_q <= wr_data[SEL_W-1:0];
      end
    end
  end

  wdog_unlock #(
    .ADDR_W  (ADDR_W),
    .SVC_ADDR(SVC_ADDR)
  ) u_unlock (
    .clk     (clk),
    .clr     (clr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .key_done(key_done)
  );

  wdog_chain #(
    .PRESCALE_W(PRESCALE_W),
    .PROG_W    (PROG_W),
    .SEL_W     (SEL_W)
  ) u_chain (
    .clk    (clk),
    .clr    (clr),
    .restart(kick),
    .step   (armed_q && mc_en),
    .sel    (sel_act_q),
    .expire (expire)
  );

  wdog_pulse #(
    .PULSE_CLKS(PULSE_CLKS)
  ) u_pulse (
    .clk    (clk),
    .rst    (rst),
    .fire   (ovf),
    .pulse_o(rst_out)
  );

endmodule

// File: rtl/wdog_seq_chk.sv
module wdog_seq_chk #(
  parameter int                PULSE_CLKS = 96,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR   = 8'h40
) (
  input logic              clk,
  input logic              rst,
  input logic              mc_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              rst_out,
  input logic              armed_q
);
  localparam int CW = $clog2(PULSE_CLKS + 2) + 1;

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst_out) hi_cnt <= hi_cnt + 1'b1;
    else         hi_cnt <= '0;
  end

  // R9: a pulse ends after exactly PULSE_CLKS cycles high
  a_r9_pulse_len: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_out) |-> hi_cnt == CW'(PULSE_CLKS));

  // R9, R11: a pulse never runs longer than PULSE_CLKS
  a_r9_pulse_max: assert property (@(posedge clk) disable iff (rst)
    hi_cnt <= CW'(PULSE_CLKS));

  // R2: a pulse only begins from the armed state
  a_r2_rise_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_out) |-> $past(armed_q));

  // R3: a time-out only lands on a machine-cycle edge
  a_r3_rise_on_step: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_out) |-> $past(mc_en));

  // R10: a time-out leaves the watchdog disarmed
  a_r10_disarm: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_out) |-> !armed_q);

  // R5: arming follows a second key byte written to the service register
  a_r5_arm_key: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(wr_en && wr_addr == SVC_ADDR && wr_data == 8'hE1));

  // R7: only a reset or a time-out disarms
  a_r7_no_disarm: assert property (@(posedge clk) disable iff (rst)
    $fell(armed_q) |-> ($past(rst) || rst_out));

endmodule

bind wdog_seq_top wdog_seq_chk #(
  .PULSE_CLKS(PULSE_CLKS),
  .ADDR_W    (ADDR_W),
  .SVC_ADDR  (SVC_ADDR)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .mc_en  (mc_en),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .wr_data(wr_data),
  .rst_out(rst_out),
  .armed_q(armed_q)
);

// File: tb/tb_wdog_seq_top.sv
module tb_wdog_seq_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          PRE_W      = 3;
  localparam int          PULSE      = 96;
  localparam logic [7:0]  SVC        = 8'h40;
  localparam logic [7:0]  PRG        = 8'h41;
  localparam int          LIMIT      = 3000;

  // {select value, expected cycles to time-out}
  localparam int VEC [0:7][0:1] = '{
    '{0, 8}, '{1, 16}, '{2, 32}, '{3, 64},
    '{4, 128}, '{5, 256}, '{6, 512}, '{7, 1024}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mc_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rst_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wdog_seq_top #(
    .PRESCALE_W(PRE_W),
    .PROG_W    (7),
    .SEL_W     (3),
    .PULSE_CLKS(PULSE),
    .ADDR_W    (8),
    .SVC_ADDR  (SVC),
    .PRG_ADDR  (PRG)
  ) dut (
    .clk    (clk),
    .rst    (rst),
    .mc_en  (mc_en),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rst_out(rst_out)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    tick();
    wr_en   = 1'b0;
  endtask

  task automatic arm();
    wr(SVC, 8'h1E);
    wr(SVC, 8'hE1);
  endtask

  // Cycles until rst_out is seen high; LIMIT+1 if it never rises
  task automatic wait_rise(input int lim, output int c);
    c = 0;
    while (!rst_out && c <= lim) begin
      tick();
      c++;
    end
  endtask

  // mode 0: plain; 1: writes during pulse; 2: ext reset inside pulse
  task automatic pulse_len(input int mode, output int len);
    len = 0;
    while (rst_out && len < 1000) begin
      if (mode == 1) begin
        wr_en = (len >= 3 && len <= 5);
        wr_addr = (len == 3) ? PRG : SVC;
        wr_data = (len == 3) ? 8'h03 : (len == 4) ? 8'h1E : 8'hE1;
      end
      if (mode == 2) rst = (len >= 10 && len < 15);
      tick();
      len++;
    end
    wr_en = 1'b0;
    rst   = 1'b0;
  endtask

  initial begin
    int c;
    int p;

    // R1: reset state
    repeat (3) tick();
    chk(rst_out == 1'b0, "R1 reset output", rst_out, 0);
    rst = 1'b0;
    wait_rise(2000, c);
    chk(c > 2000, "R1 idle without key", c, 2001);

    // R4, R2, R9: table of select values
    for (int i = 0; i < 8; i++) begin
      wr(PRG, 8'(VEC[i][0]));
      arm();
      wait_rise(LIMIT, c);
      chk(c == VEC[i][1], "R4 interval for select", c, VEC[i][1]);
      pulse_len(0, p);
      chk(p == PULSE, "R9 pulse length", p, PULSE);
    end

    // R5: broken key does not arm
    wr(SVC, 8'h1E); wr(SVC, 8'h55); wr(SVC, 8'hE1);
    wait_rise(100, c);
    chk(c > 100, "R5 interrupted key ignored", c, 101);
    wr(SVC, 8'hE1);
    wait_rise(100, c);
    chk(c > 100, "R5 lone second byte ignored", c, 101);
    wr(SVC, 8'h1E); wr(SVC, 8'h1E); wr(SVC, 8'hE1);
    wait_rise(LIMIT, c);
    chk(c == 8, "R5 repeated first byte restarts key", c, 8);
    pulse_len(0, p);

    // R3: machine-cycle enable gates the count
    arm();
    mc_en = 1'b0;
    repeat (20) tick();
    chk(rst_out == 1'b0, "R3 no count without enable", rst_out, 0);
    mc_en = 1'b1;
    wait_rise(LIMIT, c);
    chk(c == 8, "R3 count resumes with enable", c, 8);
    pulse_len(0, p);

    // R6: re-keying restarts the interval
    wr(PRG, 8'h01);
    arm();
    repeat (10) tick();
    chk(rst_out == 1'b0, "R6 no early time-out", rst_out, 0);
    arm();
    wait_rise(LIMIT, c);
    chk(c == 16, "R6 interval from last key", c, 16);
    pulse_len(0, p);

    // R7: stray writes while armed change nothing
    wr(PRG, 8'h01);
    arm();
    wr(SVC, 8'h1E); wr(SVC, 8'h55); wr(SVC, 8'h00);
    wait_rise(LIMIT, c);
    chk(c == 13, "R7 stray writes keep schedule", c + 3, 16);
    pulse_len(0, p);

    // R8: select change waits for next key
    wr(PRG, 8'h02);
    arm();
    wr(PRG, 8'h00);
    wait_rise(LIMIT, c);
    chk(c == 31, "R8 running interval keeps select", c + 1, 32);
    pulse_len(0, p);
    wr(PRG, 8'h02);
    arm();
    wr(PRG, 8'h00);
    repeat (5) tick();
    arm();
    wait_rise(LIMIT, c);
    chk(c == 8, "R8 new select at next key", c, 8);

    // R10: writes during the pulse are ignored, no repeat pulse
    pulse_len(1, p);
    chk(p == PULSE, "R10 pulse length with writes", p, PULSE);
    wait_rise(LIMIT, c);
    chk(c > LIMIT, "R10 stays disarmed", c, LIMIT + 1);

    // R11: ext reset inside pulse does not shorten it
    arm();
    wait_rise(LIMIT, c);
    pulse_len(2, p);
    chk(p == PULSE, "R11 pulse not shortened", p, PULSE);

    // R11: ext reset while armed disarms
    wr(PRG, 8'h03);
    arm();
    repeat (20) tick();
    rst = 1'b1;
    repeat (2) tick();
    rst = 1'b0;
    wait_rise(200, c);
    chk(c > 200, "R11 reset disarms", c, 201);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule